// File: doc/BRIEF.md
# Modular Polynomial Sequence Evaluator

This block evaluates the fixed-shape polynomial f(x) = x^16777213 + A·x^16777153 + B·x^3 + C·x^2 + D·x + E in the prime field of modulus p = 2^64 − 59. It does not take x as an input. It steps through x = 0, then 1, then 2, 4, 8 and so on (x = 2^r) and presents one value of f per point.

For each x it keeps the five non-constant terms in registers. When x doubles, the two high-degree terms are multiplied by the precomputed constants 2^16777213 mod p and 2^16777153 mod p. The cubic, quadratic and linear terms are doubled three, two and one times. No exponentiation happens at run time.

A caller loads the coefficients and a point count with a start pulse. It then drains the results through a valid/ready handshake. Each result carries its position in the sequence.

Top module: `pse_top`

## Requirements
- R1: While reset is asserted and after its release, out_valid is 0 and out_index is 0.
- R2: A start pulse with a nonzero count while idle presents the first point in the next cycle: out_index 0 and out_value E mod p, which is f(0).
- R3: A start pulse while a run is in progress is ignored, and so is a start pulse with count 0. Neither changes the presented points nor begins a run.
- R4: The point with out_index k ≥ 1 carries f(2^(k−1)) mod p. Point 1 is presented in the cycle after point 0 is accepted.
- R5: Every point with index 2 or more is presented exactly 65 cycles after the previous point is accepted. That is one cycle per multiplier bit plus one cycle to write back.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_value and out_index hold.
- R7: Exactly count points are presented. After the last one is accepted, out_valid falls in the next cycle and a new start is accepted.
- R8: A coefficient input of p or more is used as its value minus p.
- R9: Every presented out_value is below p.
- R10: Points beyond index 64, where 2^r has wrapped past the modulus, still carry f(2^(k−1) mod p).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run when idle and count is nonzero |
| count | input | CNT_W | Number of points to present, counting f(0) |
| coef_a | input | 64 | Coefficient of x^16777153 |
| coef_b | input | 64 | Coefficient of x^3 |
| coef_c | input | 64 | Coefficient of x^2 |
| coef_d | input | 64 | Coefficient of x |
| coef_e | input | 64 | Constant term |
| out_ready | input | 1 | Consumer accepts the presented point |
| out_valid | output | 1 | A point is presented |
| out_value | output | 64 | f(x) mod p for the presented point |
| out_index | output | CNT_W | Sequence position: 0 is x = 0, k ≥ 1 is x = 2^(k−1) |

## Verification
Each result has its own latency:
- Point 0 appears one cycle after the start edge.
- Point 1 appears one cycle after point 0 is accepted.
- Every later point appears 65 cycles after its predecessor is accepted.

The bench model tracks these latencies with its own countdown. On every falling edge it compares out_valid, out_index and out_value with the model, so an early or late point fails in the exact cycle it differs. Expected values come from direct modular exponentiation with a wide remainder, not from the recurrence. A stalling ready pattern and a run longer than 64 points exercise the hold and the wrap.

// File: rtl/pse_pkg.sv
package pse_pkg;
  localparam int W = 64;
  localparam logic [W-1:0] P = 64'hFFFF_FFFF_FFFF_FFC5;

  typedef enum logic [1:0] {S_IDLE, S_SHOW, S_CALC} pse_state_e;

  function automatic logic [W-1:0] add_mod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, P}) s = s - {1'b0, P};
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] dbl_mod(input logic [W-1:0] a);
    return add_mod(a, a);
  endfunction

  function automatic logic [W-1:0] reduce_once(input logic [W-1:0] a);
    return (a >= P) ? a - P : a;
  endfunction

  // elaboration-time only: wide product and remainder
  function automatic logic [W-1:0] const_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] pr;
    pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    pr = pr % {{W{1'b0}}, P};
    return pr[W-1:0];
  endfunction

  function automatic logic [W-1:0] pow2_mod(input int e);
    logic [W-1:0] r;
    logic [31:0]  eb;
    r  = 64'd1;
    eb = 32'(e);
    for (int i = 31; i >= 0; i--) begin
      r = const_mul(r, r);
      if (eb[i]) r = const_mul(r, 64'd2);
    end
    return r;
  endfunction
endpackage

// File: rtl/pse_rst_sync.sv
module pse_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/pse_mulmod.sv
module pse_mulmod
  import pse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  acc_q, acc_d, mc_q, mc_d, mp_q, mp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, done_q, done_d;
  logic          step_en;

  assign step_en = load | act_q | done_q;

  always_comb begin
    acc_d  = acc_q;
    mc_d   = mc_q;
    mp_d   = mp_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    done_d = 1'b0;
    if (load) begin
      acc_d = '0;
      mc_d  = a;
      mp_d  = b;
      cnt_d = CW'(W);
      act_d = 1'b1;
    end else if (act_q) begin
      acc_d = add_mod(dbl_mod(acc_q), mp_q[W-1] ? mc_q : '0);
      mp_d  = mp_q << 1;
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (step_en) begin
      acc_q  <= acc_d;
      mc_q   <= mc_d;
      mp_q   <= mp_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign result = acc_q;
  assign done   = done_q;

  // R9: the running accumulator stays a field element
  a_r9_acc_below_p: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (acc_q < P));
  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/pse_sum.sv
module pse_sum
  import pse_pkg::*;
(
  input  logic [W-1:0] t_hi,
  input  logic [W-1:0] t_mid,
  input  logic [W-1:0] t_cub,
  input  logic [W-1:0] t_sq,
  input  logic [W-1:0] t_lin,
  input  logic [W-1:0] t_con,
  output logic [W-1:0] total
);
  logic [W-1:0] s0, s1, s2, s3;

  always_comb begin
    s0    = add_mod(t_hi, t_mid);
    s1    = add_mod(t_cub, t_sq);
    s2    = add_mod(t_lin, t_con);
    s3    = add_mod(s0, s1);
    total = add_mod(s3, s2);
  end
endmodule

// File: rtl/pse_top.sv
module pse_top
  import pse_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int EXP_HI  = 16777213,
  parameter int EXP_MID = 16777153
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [63:0]      coef_a,
  input  logic [63:0]      coef_b,
  input  logic [63:0]      coef_c,
  input  logic [63:0]      coef_d,
  input  logic [63:0]      coef_e,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [63:0]      out_value,
  output logic [CNT_W-1:0] out_index
);
  localparam logic [W-1:0] K_HI  = pow2_mod(EXP_HI);
  localparam logic [W-1:0] K_MID = pow2_mod(EXP_MID);
  localparam int NMUL = 2;

  logic rst_s_n;
  pse_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  pse_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d, last_q, last_d;
  logic             zero_q, zero_d;
  logic [W-1:0]     hi_q, hi_d, mid_q, mid_d, cub_q, cub_d;
  logic [W-1:0]     sq_q, sq_d, lin_q, lin_d, con_q, con_d;
  logic             mul_load, reg_en;
  logic [W-1:0]     sum_v;

  logic [W-1:0]     m_op  [NMUL];
  logic [W-1:0]     m_k   [NMUL];
  logic [W-1:0]     m_res [NMUL];
  logic [NMUL-1:0]  m_done;

  assign m_op[0] = hi_q;
  assign m_op[1] = mid_q;
  assign m_k[0]  = K_HI;
  assign m_k[1]  = K_MID;

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    pse_mulmod u_mul (
      .clk(clk), .rst_n(rst_s_n), .load(mul_load),
      .a(m_op[g]), .b(m_k[g]), .result(m_res[g]), .done(m_done[g])
    );
  end

  pse_sum u_sum (
    .t_hi(hi_q), .t_mid(mid_q), .t_cub(cub_q), .t_sq(sq_q),
    .t_lin(lin_q), .t_con(con_q), .total(sum_v)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    last_d   = last_q;
    zero_d   = zero_q;
    hi_d     = hi_q;
    mid_d    = mid_q;
    cub_d    = cub_q;
    sq_d     = sq_q;
    lin_d    = lin_q;
    con_d    = con_q;
    mul_load = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start && (count != '0)) begin
          state_d = S_SHOW;
          idx_d   = '0;
          last_d  = count - CNT_W'(1);
          zero_d  = 1'b1;
          hi_d    = 64'd1;
          mid_d   = reduce_once(coef_a);
          cub_d   = reduce_once(coef_b);
          sq_d    = reduce_once(coef_c);
          lin_d   = reduce_once(coef_d);
          con_d   = reduce_once(coef_e);
        end
      end
      S_SHOW: begin
        if (out_ready) begin
          if (idx_q == last_q) begin
            state_d = S_IDLE;
          end else begin
            idx_d = idx_q + CNT_W'(1);
            if (zero_q) begin
              zero_d = 1'b0;
            end else begin
              state_d  = S_CALC;
              mul_load = 1'b1;
              cub_d    = dbl_mod(dbl_mod(dbl_mod(cub_q)));
              sq_d     = dbl_mod(dbl_mod(sq_q));
              lin_d    = dbl_mod(lin_q);
            end
          end
        end
      end
      S_CALC: begin
        if (&m_done) begin
          hi_d    = m_res[0];
          mid_d   = m_res[1];
          state_d = S_SHOW;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign reg_en = (state_q != S_IDLE) | start;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      zero_q  <= 1'b0;
      hi_q    <= '0;
      mid_q   <= '0;
      cub_q   <= '0;
      sq_q    <= '0;
      lin_q   <= '0;
      con_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      zero_q  <= zero_d;
      hi_q    <= hi_d;
      mid_q   <= mid_d;
      cub_q   <= cub_d;
      sq_q    <= sq_d;
      lin_q   <= lin_d;
      con_q   <= con_d;
    end
  end

  assign out_valid = (state_q == S_SHOW);
  assign out_value = zero_q ? con_q : sum_v;
  assign out_index = idx_q;

  // R9: presented values are field elements
  a_r9_value_below_p: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (out_value < P));
  // R6: a stalled point holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_index)));
  // R2: an accepted start shows point 0 next cycle
  a_r2_first: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((state_q == S_IDLE) && start && (count != '0)) |=> (out_valid && (out_index == '0)));
  // R7: acceptance of the final point ends the run
  a_r7_end: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && out_ready && (out_index == last_q)) |=> !out_valid);
endmodule

// File: tb/pse_top_test.sv
module pse_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam logic [63:0] PM = 64'hFFFF_FFFF_FFFF_FFC5;

  logic             clk, rst_n, start, out_ready, out_valid;
  logic [CNT_W-1:0] count, out_index;
  logic [63:0]      coef_a, coef_b, coef_c, coef_d, coef_e, out_value;

  pse_top #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_d(coef_d), .coef_e(coef_e),
    .out_ready(out_ready), .out_valid(out_valid), .out_value(out_value), .out_index(out_index)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int rcyc = 0;
  bit rdy_mode = 1'b0;
  bit chk_on = 1'b0;

  // reference model state
  bit          m_busy, m_valid, stall_seen;
  int          m_idx, m_tot, m_wait;
  logic [63:0] ma, mb, mc, md, me, m_val;
  logic [63:0] last_val;
  int          last_idx;

  function automatic logic [63:0] mm(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] t;
    t = ({64'd0, a} * {64'd0, b}) % {64'd0, PM};
    return t[63:0];
  endfunction

  function automatic logic [63:0] am(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] t;
    t = ({64'd0, a} + {64'd0, b}) % {64'd0, PM};
    return t[63:0];
  endfunction

  function automatic logic [63:0] pw(input logic [63:0] b, input int e);
    logic [63:0] r, s;
    r = 64'd1;
    s = b;
    for (int i = 0; i < 31; i++) begin
      if (e[i]) r = mm(r, s);
      s = mm(s, s);
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_f(input int k);
    logic [63:0] x, v;
    if (k == 0) return me;
    x = pw(64'd2, k - 1);
    v = pw(x, 16777213);
    v = am(v, mm(ma, pw(x, 16777153)));
    v = am(v, mm(mb, pw(x, 3)));
    v = am(v, mm(mc, mm(x, x)));
    v = am(v, mm(md, x));
    return am(v, me);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // model, updated from inputs that are stable at the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_idx = 0; m_wait = 0; stall_seen = 0; m_tot = 0;
    end else begin
      stall_seen = m_valid && !out_ready;
      if (!m_busy) begin
        if (start && count != 0) begin
          m_busy = 1; m_valid = 1; m_idx = 0; m_tot = int'(count);
          ma = coef_a % PM; mb = coef_b % PM; mc = coef_c % PM;
          md = coef_d % PM; me = coef_e % PM;
          m_val = ref_f(0);
        end
      end else if (m_valid) begin
        if (out_ready) begin
          if (m_idx == m_tot - 1) begin
            m_busy = 0; m_valid = 0;
          end else begin
            m_idx++;
            m_val = ref_f(m_idx);
            if (m_idx != 1) begin
              m_valid = 0;
              m_wait = 65;
            end
          end
        end
      end else begin
        m_wait--;
        if (m_wait == 0) m_valid = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (chk_on) begin
      chk(out_valid == m_valid, (m_idx <= 1) ? "R2/R4 valid" : "R5 valid",
          64'(out_valid), 64'(m_valid));
      if (m_valid && out_valid) begin
        chk(int'(out_index) == m_idx, "R4 index", 64'(out_index), 64'(m_idx));
        chk(out_value == m_val, (m_idx == 0) ? "R2 value" : (m_idx > 64) ? "R10 value" : "R4 value",
            out_value, m_val);
        chk(out_value < PM, "R9 range", out_value, PM);
      end
      if (stall_seen) begin
        chk(out_valid && out_value == last_val && int'(out_index) == last_idx,
            "R6 hold", out_value, last_val);
      end
    end
    last_val = out_value;
    last_idx = int'(out_index);
  end

  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      rcyc++;
      out_ready = rdy_mode ? ((rcyc % 3) != 0) : 1'b1;
    end
  end

  task automatic pulse_start(input int n, input logic [63:0] a, b, c, d, e);
    @(negedge clk);
    count = CNT_W'(n);
    coef_a = a; coef_b = b; coef_c = c; coef_d = d; coef_e = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (m_busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; count = '0;
    coef_a = '0; coef_b = '0; coef_c = '0; coef_d = '0; coef_e = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    chk(out_index == '0, "R1 index in reset", 64'(out_index), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
    chk_on = 1'b1;

    // small coefficients, ready held high
    pulse_start(6, 64'd3, 64'd5, 64'd7, 64'd11, 64'd13);
    chk(out_valid && out_index == '0 && out_value == 64'd13, "R2 first point", out_value, 64'd13);
    wait_idle();
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle after last", 64'(out_valid), 64'd0);

    // zero count is ignored
    pulse_start(0, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R3 zero count", 64'(out_valid), 64'd0);

    // oversized coefficients, stalling consumer, run past the wrap
    rdy_mode = 1'b1;
    pulse_start(70, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFC6, 64'h1234_5678_9ABC_DEF0,
                64'hFFFF_FFFF_FFFF_FFC4, PM + 64'd5);
    chk(out_value == 64'd5, "R8 reduced constant", out_value, 64'd5);
    repeat (150) @(negedge clk);
    pulse_start(2, 64'd9, 64'd9, 64'd9, 64'd9, 64'd9);
    repeat (2) @(negedge clk);
    chk(int'(out_index) == m_idx && m_idx > 1, "R3 busy start", 64'(out_index), 64'(m_idx));
    wait_idle();
    rdy_mode = 1'b0;

    // single-point run right after another run
    pulse_start(1, 64'd1, 64'd2, 64'd3, 64'd4, 64'd77);
    chk(out_value == 64'd77, "R7 new start accepted", out_value, 64'd77);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 single point end", 64'(out_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule